// File: doc/BRIEF.md
# Register-Mapped Byte FIFO with Flush

This block is a 64-deep, byte-wide first-in first-out buffer that software reaches through a small register bus. Two addresses are decoded. The data register pushes a byte when written. When read, it returns the oldest byte and removes it. The level register reports how many bytes are stored. A write with its top bit set empties the buffer at once and clears a sticky overflow flag.

A second, internal port lets neighbouring logic push bytes into the buffer and pop bytes from its head, in the way a serial stream engine would. Both ports share one storage array, one occupancy count and one overflow flag. Read data on both ports is combinational from the current state. Every push, pop and flush takes effect at the rising clock edge that ends the cycle in which it was requested.

Top module: `regfifo`

## Requirements
- R1: The buffer stores up to 64 bytes of 8 bits and returns them in the order they were pushed.
- R2: At address 09h, a bus write pushes `reg_wdata`. A bus read returns the oldest byte on `reg_rdata` in the same cycle and pops it at the end of that cycle.
- R3: At address 0Ah, a bus read returns the byte count in bits 6:0. The count is also driven on `fill`. After reset the count is 0, so that read returns 00h, and `overflow` is 0.
- R4: Bit 7 of a level register read is always 0, including when the count is 64 (the read value is 40h).
- R5: A bus write to address 0Ah with bit 7 set empties the buffer and clears `overflow`. A write to 0Ah with bit 7 clear changes nothing.
- R6: A push while 64 bytes are stored and no pop happens in the same cycle drops the byte and sets `overflow`. `overflow` then stays at 1 until a flush.
- R7: A pop while the buffer is empty returns 00h and leaves the count unchanged.
- R8: A push and a pop in the same cycle on a non-empty buffer leave the count unchanged. This includes a full buffer, where the push is accepted.
- R9: A flush in the same cycle as any side-port push or pop wins: the buffer ends empty.
- R10: `side_rdata` shows the oldest byte, or 00h when the buffer is empty. `side_pop` removes that byte and `side_push` stores `side_wdata`. If the bus and the side port both push in one cycle, only the bus byte is stored. If both pop in one cycle, one byte is removed.
- R11: A bus read of any other address returns 00h. A bus write to any other address has no effect. `reg_rdata` is 00h when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle of the read |
| side_push | input | 1 | Internal port push request |
| side_wdata | input | 8 | Internal port byte to push |
| side_pop | input | 1 | Internal port pop request |
| side_rdata | output | 8 | Oldest stored byte, 00h when empty |
| fill | output | 7 | Current byte count |
| overflow | output | 1 | Sticky overflow flag |

## Verification
Read data on `reg_rdata` and `side_rdata` is due in the same cycle as the request, with no register in the path. The count, the head byte and the overflow flag reflect a request only from the cycle after the rising edge that ends it. The bench drives each cycle's inputs just after a falling edge and compares every output with its queue model 1 ns later. It then advances the model at the following rising edge, so each comparison sees state up to the previous edge plus the current request.

// File: rtl/regfifo.sv
module regfifo #(
  parameter int DEPTH = 64,
  parameter int DW = 8,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 6'h09,
  parameter logic [ADDR_W-1:0] LEVEL_ADDR = 6'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              side_push,
  input  logic [DW-1:0]     side_wdata,
  input  logic              side_pop,
  output logic [DW-1:0]     side_rdata,
  output logic [$clog2(DEPTH):0] fill,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] cnt;

  wire bus_push = reg_wr && (reg_addr == DATA_ADDR);
  wire bus_pop  = reg_rd && (reg_addr == DATA_ADDR);
  wire flush    = reg_wr && (reg_addr == LEVEL_ADDR) && reg_wdata[DW-1];
  wire empty    = (cnt == '0);
  wire full     = (cnt == CW'(DEPTH));
  wire pop_ok   = (bus_pop || side_pop) && !empty;
  wire push_req = bus_push || side_push;
  wire push_ok  = push_req && (!full || pop_ok);
  wire [DW-1:0] push_byte = bus_push ? reg_wdata : side_wdata;
  wire [DW-1:0] head = empty ? '0 : mem[rptr];

  assign side_rdata = head;
  assign fill = cnt;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == DATA_ADDR) reg_rdata = head;
      else if (reg_addr == LEVEL_ADDR) reg_rdata[CW-1:0] = cnt;
    end
  end

  always_ff @(posedge clk)
    if (push_ok && !flush) mem[wptr] <= push_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      rptr <= '0;
      wptr <= '0;
      cnt <= '0;
      overflow <= 1'b0;
    end else begin
      if (pop_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      if (push_req && !push_ok) overflow <= 1'b1;
    end
  end
endmodule

module regfifo_chk #(
  parameter int DEPTH = 64,
  parameter int DW = 8,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 6'h09,
  parameter logic [ADDR_W-1:0] LEVEL_ADDR = 6'h0A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic              side_push,
  input logic              side_pop,
  input logic [DW-1:0]     side_rdata,
  input logic [$clog2(DEPTH):0] fill,
  input logic              overflow
);
  localparam int CW = $clog2(DEPTH) + 1;
  wire flush_req = reg_wr && reg_addr == LEVEL_ADDR && reg_wdata[DW-1];
  wire any_push = (reg_wr && reg_addr == DATA_ADDR) || side_push;
  wire any_pop = (reg_rd && reg_addr == DATA_ADDR) || side_pop;

  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_level_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == LEVEL_ADDR) |-> (reg_rdata[DW-1] == 1'b0));

  p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (fill == '0 && !overflow));

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush_req) |=> overflow);

  p_full_push_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH) && any_push && !any_pop && !flush_req) |=> overflow);

  p_empty_pop_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> (side_rdata == '0));

  p_push_pop_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_push && any_pop && fill != '0 && !flush_req) |=> $stable(fill));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != DATA_ADDR && reg_addr != LEVEL_ADDR) |-> (reg_rdata == '0));
endmodule

bind regfifo regfifo_chk #(
  .DEPTH(DEPTH), .DW(DW), .ADDR_W(ADDR_W),
  .DATA_ADDR(DATA_ADDR), .LEVEL_ADDR(LEVEL_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .side_push(side_push), .side_pop(side_pop), .side_rdata(side_rdata),
  .fill(fill), .overflow(overflow)
);

// File: tb/regfifo_tb_top.sv
module regfifo_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [5:0] reg_addr;
  logic       reg_wr, reg_rd, side_push, side_pop;
  logic [7:0] reg_wdata, side_wdata, reg_rdata, side_rdata;
  logic [6:0] fill;
  logic       overflow;

  regfifo dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .side_push(side_push), .side_wdata(side_wdata), .side_pop(side_pop),
    .side_rdata(side_rdata), .fill(fill), .overflow(overflow)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] q[$];
  bit ovf = 0;

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  task automatic step(string tag, bit wr, bit rd, logic [5:0] a, logic [7:0] wd,
                      bit sp, logic [7:0] sd, bit spop);
    logic [7:0] exp_rd, exp_head;
    bit bpush, bpop, flush, popn, pushn;
    logic [7:0] pbyte;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    side_push = sp; side_wdata = sd; side_pop = spop;
    #1;
    exp_head = (q.size() > 0) ? q[0] : 8'h00;
    exp_rd = 8'h00;
    if (rd && a == 6'h09) exp_rd = exp_head;
    else if (rd && a == 6'h0A) exp_rd = 8'(q.size());
    chk(tag, "reg_rdata", reg_rdata, exp_rd);
    chk(tag, "side_rdata", side_rdata, exp_head);
    chk(tag, "fill", {1'b0, fill}, 8'(q.size()));
    chk(tag, "overflow", {7'd0, overflow}, {7'd0, ovf});
    @(posedge clk);
    bpush = wr && a == 6'h09;
    bpop = rd && a == 6'h09;
    flush = wr && a == 6'h0A && wd[7];
    if (flush) begin
      q.delete();
      ovf = 0;
    end else begin
      popn = (bpop || spop) && q.size() > 0;
      pushn = bpush || sp;
      pbyte = bpush ? wd : sd;
      if (popn) void'(q.pop_front());
      if (pushn) begin
        if (q.size() < 64) q.push_back(pbyte);
        else ovf = 1;
      end
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; side_push = 0; side_pop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    side_push = 0; side_wdata = 0; side_pop = 0;
    repeat (3) @(negedge clk);
    chk("R3", "reset fill", {1'b0, fill}, 8'h00);
    chk("R3", "reset overflow", {7'd0, overflow}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    step("R3", 0, 1, 6'h0A, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step("R2", 1, 0, 6'h09, 8'h30 + 8'(i), 0, 0, 0);
    step("R3", 0, 1, 6'h0A, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R2", 0, 1, 6'h09, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R10", 0, 0, 0, 0, 1, 8'hA0 + 8'(i), 0);
    step("R10", 0, 0, 0, 0, 0, 0, 1);
    step("R8", 1, 0, 6'h09, 8'h5A, 0, 0, 1);
    step("R10", 1, 0, 6'h09, 8'h11, 1, 8'h22, 0);
    step("R10", 0, 1, 6'h09, 0, 0, 0, 1);
    for (int i = 0; q.size() < 64; i++) step("R1", 0, 0, 0, 0, 1, 8'(i * 3 + 1), 0);
    step("R4", 0, 1, 6'h0A, 0, 0, 0, 0);
    step("R6", 1, 0, 6'h09, 8'hEE, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 8'hDD, 0);
    step("R8", 0, 1, 6'h09, 0, 1, 8'h77, 0);
    step("R6", 0, 1, 6'h0A, 0, 0, 0, 0);
    while (q.size() > 0) step("R1", 0, 1, 6'h09, 0, 0, 0, 0);
    step("R7", 0, 1, 6'h09, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 1);
    step("R7", 0, 1, 6'h0A, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step("R5", 1, 0, 6'h09, 8'hC0 + 8'(i), 0, 0, 0);
    step("R5", 1, 0, 6'h0A, 8'h7F, 0, 0, 0);
    step("R5", 0, 1, 6'h0A, 0, 0, 0, 0);
    step("R5", 1, 0, 6'h0A, 8'h80, 0, 0, 0);
    step("R5", 0, 1, 6'h0A, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R9", 0, 0, 0, 0, 1, 8'h90 + 8'(i), 0);
    step("R9", 1, 0, 6'h0A, 8'hFF, 1, 8'h99, 1);
    step("R9", 0, 1, 6'h0A, 0, 0, 0, 0);
    step("R11", 1, 0, 6'h0B, 8'h80, 0, 0, 0);
    step("R11", 1, 0, 6'h05, 8'h42, 0, 0, 0);
    step("R11", 0, 1, 6'h05, 0, 0, 0, 0);
    step("R11", 0, 0, 6'h09, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule